// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

This block is a 32-bit down-counter paced by an external time-base tick. Each tick takes one from the count. When the count reaches zero it stays there, unless auto-reload is enabled. In that case the count is reloaded from a separate reload register and keeps running. Reaching zero sets a sticky status flag. The level interrupt output is that flag gated by an enable bit, and it is recomputed every cycle.

Software reaches the block through a single-cycle write port and a combinational read port. Both use the same 2-bit register select: 0 is the count, 1 is the reload value, 2 is the control register and 3 is the status register. Status bits are cleared by writing 1 to them. The time base, any other timers and the interrupt controller sit outside this block.

Top module: `reload_decr_timer`

## Requirements
- R1: With no write to the count, each cycle with `tick_i` high lowers a nonzero count by exactly one. A cycle without a tick leaves the count unchanged.
- R2: A count of zero stays at zero on further ticks and reads back as 0. It never wraps to a large value.
- R3: The tick that takes the count from 1 to 0 sets the status flag, which is status bit 27 (bit 0 is the LSB). The flag reads back from select 3 in the next cycle.
- R4: With auto-reload off, ticks while the count is already 0 do not set the status flag again after it has been cleared.
- R5: `irq_o` is high exactly when status bit 27 and the interrupt enable (control bit 26) are both 1. Writing the control register with bit 26 set while the flag is already 1 raises `irq_o` in the next cycle.
- R6: A write to the status register clears each bit written as 1 and keeps each bit written as 0. Clearing bit 27 drops `irq_o` in the next cycle.
- R7: With auto-reload (control bit 22) at 1, the expiring tick loads the count from the reload register (select 1) and counting continues. A reload value of 0 leaves the count at 0.
- R8: A software write to the count (select 0) takes priority over a decrement or reload in the same cycle, and it cancels that cycle's expiry. Writing any value, including one with bit 31 set or 0, neither sets the flag nor raises `irq_o`.
- R9: If an expiry and a status write clearing bit 27 fall in the same cycle, the flag ends up set.
- R10: Reset clears the count, the reload value, the control and status registers, and `irq_o`. Control reads back only bits 26 and 22, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, one count step per cycle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 count, 1 reload, 2 control, 3 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as the write select |
| rd_data_o | output | 32 | Combinational readback of the selected register |
| irq_o | output | 1 | Level interrupt: status flag AND enable |

## Verification
Two pairs of actions can collide in one cycle. The first is a software write to the count landing on the very tick that would take the count from 1 to 0. The second is a status-clear write landing on an expiring tick. The bench provokes each collision by driving the write strobe and `tick_i` together in the same cycle. The first case passes if the written value is read back and the status flag stays clear. The second passes if the flag stays set despite the clear.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned STAT_BIT = 27;
  localparam int unsigned IE_BIT   = 26;
  localparam int unsigned ARE_BIT  = 22;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } dtmr_sel_e;
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  input  logic         are,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] rld_q, rld_n;
  logic         cnt_en, rld_en;
  logic         nonzero, at_one;

  assign nonzero = (cnt_q != ZERO);
  assign at_one  = (cnt_q == ONE);

  // Next-state: write first, then the tick path (decrement or reload).
  always_comb begin
    cnt_n    = cnt_q;
    expire_o = 1'b0;
    if (wr_cnt) begin
      cnt_n = wdata;
    end else if (tick && nonzero) begin
      if (at_one) begin
        expire_o = 1'b1;
        cnt_n    = are ? rld_q : ZERO;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  assign cnt_en = wr_cnt | (tick & nonzero);
  assign rld_en = wr_rld;
  assign rld_n  = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= ZERO;
    end else if (rld_en) begin
      rld_q <= rld_n;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl #(
  parameter int unsigned W        = 32,
  parameter int unsigned STAT_BIT = 27,
  parameter int unsigned IE_BIT   = 26,
  parameter int unsigned ARE_BIT  = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  input  logic         expire,
  output logic         ie_o,
  output logic         are_o,
  output logic         stat_o,
  output logic [W-1:0] ctrl_rd_o,
  output logic [W-1:0] stat_rd_o,
  output logic         irq_o
);
  logic ie_q, ie_n, are_q, are_n;
  logic stat_q, stat_n, stat_en;
  logic clr_req;

  assign ie_n  = wdata[IE_BIT];
  assign are_n = wdata[ARE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      are_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q  <= ie_n;
      are_q <= are_n;
    end
  end

  // Sticky flag: a new expiry beats a concurrent write-one-to-clear.
  assign clr_req = wr_stat & wdata[STAT_BIT];
  always_comb begin
    stat_n = stat_q;
    if (expire) begin
      stat_n = 1'b1;
    end else if (clr_req) begin
      stat_n = 1'b0;
    end
  end
  assign stat_en = expire | clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (stat_en) begin
      stat_q <= stat_n;
    end
  end

  always_comb begin
    ctrl_rd_o          = '0;
    ctrl_rd_o[IE_BIT]  = ie_q;
    ctrl_rd_o[ARE_BIT] = are_q;
    stat_rd_o          = '0;
    stat_rd_o[STAT_BIT] = stat_q;
  end

  assign ie_o   = ie_q;
  assign are_o  = are_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q & ie_q;
endmodule

// File: rtl/dtmr_readmux.sv
module dtmr_readmux #(
  parameter int unsigned W     = 32,
  parameter int unsigned SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     cnt,
  input  logic [W-1:0]     rld,
  input  logic [W-1:0]     ctrl,
  input  logic [W-1:0]     stat,
  output logic [W-1:0]     dout
);
  import dtmr_pkg::*;
  always_comb begin
    unique case (sel)
      SEL_COUNT:  dout = cnt;
      SEL_RELOAD: dout = rld;
      SEL_CTRL:   dout = ctrl;
      SEL_STAT:   dout = stat;
      default:    dout = '0;
    endcase
  end
endmodule

// File: rtl/reload_decr_timer.sv
module reload_decr_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  import dtmr_pkg::*;

  logic wr_cnt, wr_rld, wr_ctrl, wr_stat;
  logic [DATA_W-1:0] cnt_w, rld_w, ctrl_rd_w, stat_rd_w;
  logic expire_w, ie_w, are_w, stat_w;

  assign wr_cnt  = wr_en_i & (wr_sel_i == SEL_COUNT);
  assign wr_rld  = wr_en_i & (wr_sel_i == SEL_RELOAD);
  assign wr_ctrl = wr_en_i & (wr_sel_i == SEL_CTRL);
  assign wr_stat = wr_en_i & (wr_sel_i == SEL_STAT);

  dtmr_counter #(.W(DATA_W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .wr_cnt   (wr_cnt),
    .wr_rld   (wr_rld),
    .wdata    (wr_data_i),
    .are      (are_w),
    .cnt_o    (cnt_w),
    .rld_o    (rld_w),
    .expire_o (expire_w)
  );

  dtmr_ctrl #(
    .W(DATA_W), .STAT_BIT(STAT_BIT), .IE_BIT(IE_BIT), .ARE_BIT(ARE_BIT)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_stat   (wr_stat),
    .wdata     (wr_data_i),
    .expire    (expire_w),
    .ie_o      (ie_w),
    .are_o     (are_w),
    .stat_o    (stat_w),
    .ctrl_rd_o (ctrl_rd_w),
    .stat_rd_o (stat_rd_w),
    .irq_o     (irq_o)
  );

  dtmr_readmux #(.W(DATA_W), .SEL_W(SEL_W)) i_rdmux (
    .sel  (rd_sel_i),
    .cnt  (cnt_w),
    .rld  (rld_w),
    .ctrl (ctrl_rd_w),
    .stat (stat_rd_w),
    .dout (rd_data_o)
  );
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
  parameter int unsigned W = 32,
  parameter int unsigned STAT_BIT = 27
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_cnt,
  input logic         wr_stat,
  input logic         wr_ctrl,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic         stat,
  input logic         ie,
  input logic         irq
);
  logic hit_one;
  assign hit_one = tick && !wr_cnt && (cnt == {{(W-1){1'b0}}, 1'b1});

  a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt > 1) |=> (cnt == $past(cnt) - 1));

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt == '0) |=> (cnt == '0));

  a_r3_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    hit_one |=> stat);

  a_r4_flag_only_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> $past(hit_one));

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit_one) || $past(wr_ctrl)));

  a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[STAT_BIT] && !hit_one) |=> !irq);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(wdata)));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_one && wr_stat) |=> stat);
endmodule

bind reload_decr_timer dtmr_checker #(.W(32), .STAT_BIT(27)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_i),
  .wr_cnt  (wr_cnt),
  .wr_stat (wr_stat),
  .wr_ctrl (wr_ctrl),
  .wdata   (wr_data_i),
  .cnt     (cnt_w),
  .stat    (stat_w),
  .ie      (ie_w),
  .irq     (irq_o)
);

// File: tb/test_reload_decr_timer.sv
`timescale 1ns/1ps
module test_reload_decr_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [31:0] wr_data_i;
  logic [1:0]  rd_sel_i;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [31:0] ST  = 32'h1 << 27;
  localparam logic [31:0] IE  = 32'h1 << 26;
  localparam logic [31:0] ARE = 32'h1 << 22;

  always #2.5 clk = ~clk;

  reload_decr_timer i_reload_decr_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel_i = sel;
    #0.5;
    d = rd_data_o;
  endtask

  // Called at a negative edge; returns at the following negative edge.
  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic tk);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d; tick_i = tk;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = '0;
    wr_data_i = '0; rd_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d); chk("R10 reset readback", d, 32'h0);
    end
    chk("R10 reset irq", {31'b0, irq_o}, 32'h0);

    // R10 control keeps only bits 26 and 22
    wr(2'd2, 32'hFFFF_FFFF, 1'b0);
    rd(2'd2, d); chk("R10 control readback mask", d, IE | ARE);
    wr(2'd2, 32'h0, 1'b0);

    // R1 R2 R3: sweep start values and tick counts, auto-reload off
    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < 8; k++) begin
        wr(2'd3, 32'hFFFF_FFFF, 1'b0);
        wr(2'd0, n, 1'b0);
        ticks(k);
        rd(2'd0, d); chk("R1 R2 count after ticks", d, (k >= n) ? 32'd0 : 32'(n - k));
        rd(2'd3, d); chk("R3 status after ticks", d, (n > 0 && k >= n) ? ST : 32'h0);
      end
    end

    // R1 no tick holds the count
    wr(2'd0, 32'd7, 1'b0);
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R1 hold without tick", d, 32'd7);

    // R4 no second set once parked at zero
    wr(2'd0, 32'd1, 1'b0);
    ticks(1);
    wr(2'd3, ST, 1'b0);
    ticks(5);
    rd(2'd3, d); chk("R4 flag not re-set at zero", d, 32'h0);

    // R7 auto-reload sweep
    wr(2'd2, ARE, 1'b0);
    for (int n = 1; n < 4; n++) begin
      for (int r = 0; r < 4; r++) begin
        for (int k = 0; k < 10; k++) begin
          int e;
          wr(2'd1, r, 1'b0);
          wr(2'd0, n, 1'b0);
          ticks(k);
          if (k < n) e = n - k;
          else if (r == 0) e = 0;
          else e = r - ((k - n) % r);
          rd(2'd0, d); chk("R7 auto-reload count", d, 32'(e));
        end
      end
    end
    wr(2'd2, 32'h0, 1'b0);

    // R8 MSB write with enable on raises nothing
    wr(2'd3, ST, 1'b0);
    wr(2'd2, IE, 1'b0);
    wr(2'd0, 32'h8000_0000, 1'b0);
    rd(2'd3, d); chk("R8 msb write no flag", d, 32'h0);
    chk("R8 msb write no irq", {31'b0, irq_o}, 32'h0);
    wr(2'd0, 32'h0, 1'b0);
    chk("R8 zero write no irq", {31'b0, irq_o}, 32'h0);

    // R5 gating and immediate fire on enable
    wr(2'd2, 32'h0, 1'b0);
    wr(2'd0, 32'd2, 1'b0);
    ticks(2);
    chk("R5 flag set enable off", {31'b0, irq_o}, 32'h0);
    wr(2'd2, IE, 1'b0);
    chk("R5 enable with flag set fires", {31'b0, irq_o}, 32'h1);

    // R6 write zero keeps, write one clears
    wr(2'd3, ~ST, 1'b0);
    rd(2'd3, d); chk("R6 zero bit keeps flag", d, ST);
    chk("R6 irq kept", {31'b0, irq_o}, 32'h1);
    wr(2'd3, ST, 1'b0);
    rd(2'd3, d); chk("R6 one bit clears flag", d, 32'h0);
    chk("R6 irq dropped", {31'b0, irq_o}, 32'h0);

    // R8 collision: count write on the expiring tick
    wr(2'd0, 32'd1, 1'b0);
    wr(2'd0, 32'd9, 1'b1);
    rd(2'd0, d); chk("R8 write beats expiry count", d, 32'd9);
    rd(2'd3, d); chk("R8 write cancels expiry flag", d, 32'h0);
    chk("R8 no irq on cancelled expiry", {31'b0, irq_o}, 32'h0);

    // R9 collision: status clear on the expiring tick
    wr(2'd0, 32'd1, 1'b0);
    wr(2'd3, ST, 1'b1);
    rd(2'd3, d); chk("R9 set beats clear", d, ST);
    chk("R9 irq stays", {31'b0, irq_o}, 32'h1);

    // R10 reset again clears everything
    wr(2'd1, 32'd5, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d); chk("R10 re-reset readback", d, 32'h0);
    end
    chk("R10 re-reset irq", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule